// File: doc/BRIEF.md
# Row-Strobed Dot Matrix Scanner with Dimming

This block refreshes a ten-character display of 5x5 dot cells. The bitmap sits in a RAM outside the block that is read one row at a time: one read returns the five column bits of that row for all ten characters, 50 bits in all. The scanner picks a row, drives that row's enable line and places the 50 column bits on the column outputs. After a fixed number of multiplex ticks it moves on to the next row. Rows 0 to 4 are visited in turn, and then the cycle starts again.

A multiplex tick comes either from an internal divider running on the system clock or from an external tick input. A select input chooses between them. Each row slot lasts 320 ticks and is split into 15 equal sub-slots. The brightness level decides for how many of the leading sub-slots the row is lit. Outside the lit sub-slots, both the row enables and the columns stay dark.

A lamp-test control lights every dot at a fixed mid brightness and ignores the RAM. A power-down control blanks the display and freezes the scan position and the divider, so the scan carries on where it stopped. A synchronous reset returns the scan to row 0, tick 0. This keeps several units that share a multiplex tick in step.

Top module: `led_row_scanner`

## Requirements
- R1: After reset, the scan is at row 0, tick 0. With level 0, row_en reads 5'b00001 in the first cycle after reset.
- R2: Each row slot lasts 320 multiplex ticks. Rows advance 0,1,2,3,4 and then return to 0. At most one bit of row_en is ever set, and bit r stands for row r. rd_row always names the current scan row.
- R3: The level input sets the lit sub-slot count N. Levels 0..6 give N = 15, 8, 6, 4, 3, 2, 1, and level 7 acts like level 6. Within a slot, the row is lit at tick index k when k*15 < N*320. This gives 320, 171, 128, 86, 64, 43 and 22 lit ticks per slot.
- R4: While a row is lit, col equals rd_data, where bit 5*c+j is column j of character c. Whenever row_en is zero, col is all zeros.
- R5: With lamp_test high, all 50 col bits are 1 while lit, whatever rd_data holds. The duty is that of 8 sub-slots (171 lit ticks per slot), whatever the level input holds.
- R6: With power_down high, row_en and col are zero and the scan position and the internal divider hold still. Power down takes precedence over lamp test. On release, the scan resumes from the held position.
- R7: With use_ext_clk high, the scan advances once per clock in which ext_tick is high. With use_ext_clk low, it advances once every OSC_DIV clocks (default 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| use_ext_clk | input | 1 | 1 selects ext_tick as the multiplex tick, 0 selects the internal divider |
| ext_tick | input | 1 | External multiplex tick, one clock wide per tick |
| level | input | 3 | Brightness level, 0 brightest |
| lamp_test | input | 1 | Light all dots at mid brightness |
| power_down | input | 1 | Blank the display and freeze the scan |
| rd_row | output | 3 | Row index presented to the bitmap RAM |
| rd_data | input | 50 | Column bits of row rd_row for all characters |
| row_en | output | 5 | One-hot row strobe |
| col | output | 50 | Column drive, gated by the strobe |

## Verification
Every brightness level is run through a full row slot over a RAM image that differs from row to row. The lit tick count tells the duty levels apart, and comparing columns per cycle shows whether the columns follow the addressed row and go dark outside the strobe. A full-frame walk at sub-slot starts exposes a wrong row order or a wrong wrap. Lamp test runs over a non-trivial RAM image and power down is entered mid-slot. Together these separate RAM-ignoring and position-holding behaviour from simple blanking. Runs with ext_tick held low and with the internal divider separate the two tick sources.

// File: rtl/led_scan_pkg.sv
package led_scan_pkg;

    localparam int NUM_ROWS   = 5;
    localparam int NUM_CHARS  = 10;
    localparam int CHAR_COLS  = 5;
    localparam int NUM_COLS   = NUM_CHARS * CHAR_COLS;
    localparam int SUBSLOTS   = 15;
    localparam int LAMP_SUBS  = 8;
    localparam int ROW_BITS   = $clog2(NUM_ROWS);

    typedef enum logic [1:0] {
        MODE_DARK   = 2'd0,
        MODE_LAMP   = 2'd1,
        MODE_NORMAL = 2'd2
    } scan_mode_e;

    typedef struct packed {
        logic [2:0] level;
        logic       lamp;
        logic       sleep;
    } scan_ctrl_t;

    function automatic logic [3:0] lit_subslots(input logic [2:0] lvl);
        case (lvl)
            3'd0:    return 4'd15;
            3'd1:    return 4'd8;
            3'd2:    return 4'd6;
            3'd3:    return 4'd4;
            3'd4:    return 4'd3;
            3'd5:    return 4'd2;
            default: return 4'd1;
        endcase
    endfunction

endpackage

// File: rtl/mux_tick_gen.sv
module mux_tick_gen #(
    parameter int OSC_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic use_ext,
    input  logic ext_tick,
    input  logic hold,
    output logic tick
);
    localparam int DW = (OSC_DIV > 1) ? $clog2(OSC_DIV) : 1;

    logic [DW-1:0] div_q;
    logic          int_tick;

    assign int_tick = (div_q == DW'(OSC_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst)
            div_q <= '0;
        else if (!hold)
            div_q <= int_tick ? '0 : div_q + 1'b1;
    end

    assign tick = !hold && (use_ext ? ext_tick : int_tick);

endmodule

// File: rtl/scan_counter.sv
module scan_counter #(
    parameter int ROW_TICKS = 320,
    parameter int ROWS      = 5
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         step,
    output logic [$clog2(ROWS)-1:0]      row,
    output logic [$clog2(ROW_TICKS)-1:0] pos
);
    localparam int RW = $clog2(ROWS);
    localparam int TW = $clog2(ROW_TICKS);

    logic slot_end;
    assign slot_end = (pos == TW'(ROW_TICKS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            row <= '0;
            pos <= '0;
        end else if (step) begin
            if (slot_end) begin
                pos <= '0;
                row <= (row == RW'(ROWS - 1)) ? '0 : row + 1'b1;
            end else begin
                pos <= pos + 1'b1;
            end
        end
    end

    // R2: a slot ending on a tick opens the next row at tick 0
    a_r2_slot_wrap: assert property (@(posedge clk) disable iff (rst)
        (step && slot_end) |=> (pos == '0 &&
            row == (($past(row) == RW'(ROWS - 1)) ? '0 : $past(row) + 1'b1)));

    // R2: row index stays inside the panel
    a_r2_row_range: assert property (@(posedge clk) disable iff (rst)
        row < RW'(ROWS));

endmodule

// File: rtl/strobe_gate.sv
module strobe_gate
    import led_scan_pkg::*;
#(
    parameter int ROW_TICKS = 320
) (
    input  scan_ctrl_t                   ctrl,
    input  logic [$clog2(ROW_TICKS)-1:0] pos,
    output scan_mode_e                   mode,
    output logic                         lit
);
    logic [3:0]  n_sub;
    logic [31:0] lhs, rhs;

    always_comb begin
        if (ctrl.sleep)     mode = MODE_DARK;
        else if (ctrl.lamp) mode = MODE_LAMP;
        else                mode = MODE_NORMAL;

        n_sub = (mode == MODE_LAMP) ? 4'(LAMP_SUBS) : lit_subslots(ctrl.level);
        lhs   = 32'(pos) * 32'(SUBSLOTS);
        rhs   = 32'(n_sub) * 32'(ROW_TICKS);
        lit   = (mode != MODE_DARK) && (lhs < rhs);
    end

endmodule

// File: rtl/led_row_scanner.sv
module led_row_scanner
    import led_scan_pkg::*;
#(
    parameter int ROW_TICKS = 320,
    parameter int OSC_DIV   = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                use_ext_clk,
    input  logic                ext_tick,
    input  logic [2:0]          level,
    input  logic                lamp_test,
    input  logic                power_down,
    output logic [ROW_BITS-1:0] rd_row,
    input  logic [NUM_COLS-1:0] rd_data,
    output logic [NUM_ROWS-1:0] row_en,
    output logic [NUM_COLS-1:0] col
);
    localparam int TW = $clog2(ROW_TICKS);

    scan_ctrl_t          ctrl;
    scan_mode_e          mode;
    logic                tick;
    logic                lit;
    logic [ROW_BITS-1:0] scan_row;
    logic [TW-1:0]       scan_pos;

    assign ctrl = '{level: level, lamp: lamp_test, sleep: power_down};

    mux_tick_gen #(.OSC_DIV(OSC_DIV)) u_tick (
        .clk      (clk),
        .rst      (rst),
        .use_ext  (use_ext_clk),
        .ext_tick (ext_tick),
        .hold     (power_down),
        .tick     (tick)
    );

    scan_counter #(.ROW_TICKS(ROW_TICKS), .ROWS(NUM_ROWS)) u_scan (
        .clk  (clk),
        .rst  (rst),
        .step (tick),
        .row  (scan_row),
        .pos  (scan_pos)
    );

    strobe_gate #(.ROW_TICKS(ROW_TICKS)) u_gate (
        .ctrl (ctrl),
        .pos  (scan_pos),
        .mode (mode),
        .lit  (lit)
    );

    assign rd_row = scan_row;

    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
        assign row_en[r] = lit && (scan_row == ROW_BITS'(r));
    end

    for (genvar c = 0; c < NUM_CHARS; c++) begin : g_char
        assign col[c*CHAR_COLS +: CHAR_COLS] =
            !lit                ? '0 :
            (mode == MODE_LAMP) ? '1 :
                                  rd_data[c*CHAR_COLS +: CHAR_COLS];
    end

    // R2: never two rows at once
    a_r2_one_row: assert property (@(posedge clk) disable iff (rst)
        $onehot0(row_en));

    // R4: no column drive outside a strobe
    a_r4_cols_dark: assert property (@(posedge clk) disable iff (rst)
        (row_en == '0) |-> (col == '0));

    // R5: lamp test lights every column of the strobed row
    a_r5_lamp_full: assert property (@(posedge clk) disable iff (rst)
        (lamp_test && !power_down && row_en != '0) |-> (&col));

    // R6: power down blanks the rows
    a_r6_sleep_dark: assert property (@(posedge clk) disable iff (rst)
        power_down |-> (row_en == '0));

    // R6: scan position frozen across a power-down cycle
    a_r6_sleep_hold: assert property (@(posedge clk) disable iff (rst)
        power_down |=> ($stable(scan_row) && $stable(scan_pos)));

endmodule

// File: tb/sim_led_row_scanner.sv
module sim_led_row_scanner;
    import led_scan_pkg::*;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                use_ext_clk = 1'b1;
    logic                ext_tick = 1'b1;
    logic [2:0]          level = 3'd0;
    logic                lamp_test = 1'b0;
    logic                power_down = 1'b0;
    logic [ROW_BITS-1:0] rd_row;
    logic [NUM_COLS-1:0] rd_data;
    logic [NUM_ROWS-1:0] row_en;
    logic [NUM_COLS-1:0] col;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    led_row_scanner u0 (
        .clk(clk), .rst(rst), .use_ext_clk(use_ext_clk), .ext_tick(ext_tick),
        .level(level), .lamp_test(lamp_test), .power_down(power_down),
        .rd_row(rd_row), .rd_data(rd_data), .row_en(row_en), .col(col)
    );

    function automatic logic [NUM_COLS-1:0] ram_word(input int r);
        logic [NUM_COLS-1:0] w;
        w = 50'h1_2345_6789_ABCD * 50'(r + 3);
        return w ^ {25{2'b10}};
    endfunction

    assign rd_data = ram_word(int'(rd_row));

    // level, expected lit ticks per slot
    localparam int NV = 8;
    localparam int VEC [NV][2] = '{
        '{0, 320}, '{1, 171}, '{2, 128}, '{3, 86},
        '{4, 64},  '{5, 43},  '{6, 22},  '{7, 22}
    };

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
    endtask

    // one row slot: count lit cycles and column mismatches, samples at negedge
    task automatic run_slot(input logic [NUM_ROWS-1:0] want_row, input bit lamp,
                            output int lit_cnt, output int col_bad);
        lit_cnt = 0;
        col_bad = 0;
        for (int i = 0; i < 320; i++) begin
            if (row_en == want_row) begin
                lit_cnt++;
                if (col != (lamp ? {NUM_COLS{1'b1}} : ram_word(int'(rd_row)))) col_bad++;
            end else begin
                if (row_en != '0) col_bad++;
                if (col != '0) col_bad++;
            end
            @(negedge clk);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int lc, cb, k;

        // R1: reset state
        do_reset();
        check(row_en == 5'b00001, "R1 reset row", row_en, 1);
        check(rd_row == 3'd0, "R1 reset rd_row", rd_row, 0);

        // R3/R4: table of levels
        for (int v = 0; v < NV; v++) begin
            level = 3'(VEC[v][0]);
            do_reset();
            run_slot(5'b00001, 1'b0, lc, cb);
            check(lc == VEC[v][1], "R3 lit ticks", lc, VEC[v][1]);
            check(cb == 0, "R4 column gating", cb, 0);
            check(row_en == 5'b00010, "R2 next row", row_en, 2);
        end

        // R2: full frame order and wrap
        level = 3'd0;
        do_reset();
        for (int r = 0; r < 6; r++) begin
            check(row_en == 5'(1 << (r % 5)), "R2 frame order", row_en, 1 << (r % 5));
            check(rd_row == 3'(r % 5), "R2 rd_row", rd_row, r % 5);
            repeat (320) @(negedge clk);
        end

        // R5: lamp test ignores level and RAM
        level = 3'd5;
        lamp_test = 1'b1;
        do_reset();
        run_slot(5'b00001, 1'b1, lc, cb);
        check(lc == 171, "R5 lamp duty", lc, 171);
        check(cb == 0, "R5 lamp columns", cb, 0);

        // R6: power down beats lamp, holds position mid-slot
        level = 3'd0;
        do_reset();
        repeat (100) @(negedge clk);
        power_down = 1'b1;
        cb = 0;
        for (int i = 0; i < 500; i++) begin
            #1;
            if (row_en != '0 || col != '0) cb++;
            @(negedge clk);
        end
        check(cb == 0, "R6 dark while asleep", cb, 0);
        power_down = 1'b0;
        lamp_test = 1'b0;
        #1;
        check(row_en == 5'b00001, "R6 resume row", row_en, 1);
        k = 0;
        while (row_en != 5'b00010 && k < 1000) begin
            @(negedge clk);
            k++;
        end
        check(k == 220, "R6 resume position", k, 220);

        // R7: external tick held low stops the scan
        level = 3'd6;
        ext_tick = 1'b0;
        do_reset();
        repeat (1000) @(negedge clk);
        check(row_en == 5'b00001, "R7 ext tick gating", row_en, 1);

        // R7: internal divider, one tick per 4 clocks
        use_ext_clk = 1'b0;
        level = 3'd0;
        do_reset();
        repeat (1279) @(negedge clk);
        check(row_en == 5'b00001, "R7 internal before", row_en, 1);
        @(negedge clk);
        check(row_en == 5'b00010, "R7 internal after", row_en, 2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule